// File: doc/BRIEF.md
# Gated Timer with Single-Pulse Capture

This block is a 16-bit up-counter whose advance is qualified by an external gate signal. Each cycle in which the count-enable input is high adds one to the counter, provided the timer is switched on and, when gating is in use, the qualified gate is active. The raw gate passes through a two-flop synchronizer and an optional inversion. It can then feed a toggle flip-flop that flips on every active-going gate edge, so that the qualified level stays high for one whole gate period.

Single-pulse capture lets software take one measurement and then freeze the result. Software selects single-pulse mode and then pulses the arm input. Counting opens on the next rising edge of the qualified gate and closes on its trailing edge, at which point the arm flag clears itself. Further gate activity is ignored until software arms again. With toggle mode also selected, the window spans rise to rise of the raw gate, which gives a period measurement. A sticky interrupt flag marks the end of every qualified gate window. A sticky overflow flag marks the wrap of the counter.

The single-pulse controller is a three-state machine. SP_IDLE means disarmed. SP_ARMED means armed and waiting for a rising edge. SP_RUN means counting inside the pulse. ARM moves SP_IDLE to SP_ARMED when arm_set is high in single-pulse mode. START moves SP_ARMED to SP_RUN on a rising qualified edge. FINISH moves SP_RUN to SP_IDLE when the qualified level drops. CANCEL forces SP_IDLE from any state whenever single-pulse mode is off.

Top module: `gated_pulse_timer`

## Requirements
- R1: After reset, count is 0 and armed, gate_irq and ovf_flag are all 0.
- R2: With gate_use low and ctl_on high, count rises by exactly one for each clock cycle in which cnt_en is high. It never changes by more than one per cycle.
- R3: While ctl_on is low, count does not change, whatever cnt_en and gate_in do.
- R4: With gate_use high and single-pulse mode off, count advances only while the qualified gate is high. The qualified gate follows gate_in when gate_inv=0 and its inverse when gate_inv=1, and it is readable on gate_val. A gate pulse lasting H clock cycles with cnt_en held high adds exactly H.
- R5: When gate_use and ctl_on are high, gate_irq is set on the falling edge of gate_val. It stays set until irq_clr is pulsed.
- R6: In single-pulse mode, pulsing arm_set sets armed. Exactly the next qualified gate pulse is counted, and armed returns to 0 when that pulse ends.
- R7: While single-pulse mode is on and armed is 0, count does not change. Further gate pulses neither count nor set gate_irq until arm_set is pulsed again.
- R8: If arming happens while the qualified gate is already high, counting waits for the next rising edge of that gate.
- R9: Clearing single-pulse mode forces armed to 0 on the next cycle.
- R10: With toggle mode and single-pulse mode both on, the counter accumulates over one full gate period, from one active-going gate edge to the next. A period of P cycles adds P.
- R11: When count wraps from 0xFFFF to 0, ovf_flag is set. It stays set until ovf_clr is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable pulse, one increment per high cycle |
| gate_in | input | 1 | Raw asynchronous gate input |
| ctl_on | input | 1 | Timer enable |
| gate_use | input | 1 | Gate qualification enable |
| gate_inv | input | 1 | Gate polarity inversion |
| tgl_mode | input | 1 | Toggle mode select |
| sp_mode | input | 1 | Single-pulse mode select |
| arm_set | input | 1 | Software pulse that arms single-pulse capture |
| irq_clr | input | 1 | Software clear of the gate interrupt flag |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| gate_val | output | 1 | Qualified gate level (counting window) |
| armed | output | 1 | Single-pulse go/done status |
| count | output | 16 | Counter value |
| gate_irq | output | 1 | Gate-window-end interrupt flag |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The bench arms capture while the gate is already high. A design that took the level rather than the edge would count the tail of that pulse and report the wrong width. It sends a second pulse after a capture has completed. A self-clearing flag that did not hold would add that pulse or raise the interrupt again. A toggle-mode period measurement and a wrap run from 0xFFFF complete the set. A toggle flop that was not cleared, or a window one cycle off, would give P±1. A missed wrap would leave ovf_flag low.

// File: rtl/gt_pkg.sv
package gt_pkg;
    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_ARMED = 2'd1,
        SP_RUN   = 2'd2
    } sp_state_t;
endpackage

// File: rtl/gt_gate_qual.sv
module gt_gate_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic gate_inv,
    input  logic tgl_mode,
    input  logic ctl_on,
    output logic q_lvl
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         pol_lvl;
    logic         pol_d;
    logic         pol_rise;
    logic         tff;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= gate_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], gate_in};
            end
        end
    endgenerate

    assign pol_lvl  = sync_q[MSB] ^ gate_inv;
    assign pol_rise = pol_lvl & ~pol_d;

    always_ff @(posedge clk) begin
        if (!rst_n) pol_d <= 1'b0;
        else        pol_d <= pol_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !tgl_mode || !ctl_on) tff <= 1'b0;
        else if (pol_rise)                  tff <= ~tff;
    end

    assign q_lvl = tgl_mode ? tff : pol_lvl;
endmodule

// File: rtl/gt_pulse_fsm.sv
module gt_pulse_fsm
    import gt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_lvl,
    input  logic sp_mode,
    input  logic arm_set,
    input  logic gate_use,
    input  logic ctl_on,
    input  logic irq_clr,
    output logic win,
    output logic armed,
    output logic gate_irq
);
    sp_state_t st, st_nx;
    logic      q_prev;
    logic      q_rise;
    logic      win_d;

    assign q_rise = q_lvl & ~q_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SP_IDLE;
            q_prev <= 1'b0;
            win_d  <= 1'b0;
        end else begin
            st     <= st_nx;
            q_prev <= q_lvl;
            win_d  <= win;
        end
    end

    always_comb begin
        st_nx = st;
        if (!sp_mode) begin
            st_nx = SP_IDLE;
        end else begin
            unique case (st)
                SP_IDLE:  if (arm_set) st_nx = SP_ARMED;
                SP_ARMED: if (q_rise)  st_nx = SP_RUN;
                SP_RUN:   if (!q_lvl)  st_nx = SP_IDLE;
                default:               st_nx = SP_IDLE;
            endcase
        end
    end

    always_comb begin
        armed = 1'b0;
        win   = 1'b0;
        if (!sp_mode) begin
            win = q_lvl;
        end else begin
            unique case (st)
                SP_IDLE:  begin armed = 1'b0; win = 1'b0;   end
                SP_ARMED: begin armed = 1'b1; win = q_rise; end
                SP_RUN:   begin armed = 1'b1; win = q_lvl;  end
                default:  begin armed = 1'b0; win = 1'b0;   end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                gate_irq <= 1'b0;
        else if (win_d && !win && gate_use && ctl_on) gate_irq <= 1'b1;
        else if (irq_clr)                          gate_irq <= 1'b0;
    end
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag
);
    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   ovf_flag <= 1'b0;
        else if (inc && count == TOP) ovf_flag <= 1'b1;
        else if (ovf_clr)             ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/gated_pulse_timer.sv
module gated_pulse_timer #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate_in,
    input  logic             ctl_on,
    input  logic             gate_use,
    input  logic             gate_inv,
    input  logic             tgl_mode,
    input  logic             sp_mode,
    input  logic             arm_set,
    input  logic             irq_clr,
    input  logic             ovf_clr,
    output logic             gate_val,
    output logic             armed,
    output logic [WIDTH-1:0] count,
    output logic             gate_irq,
    output logic             ovf_flag
);
    logic q_lvl;
    logic win;
    logic inc;

    gt_gate_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_in  (gate_in),
        .gate_inv (gate_inv),
        .tgl_mode (tgl_mode),
        .ctl_on   (ctl_on),
        .q_lvl    (q_lvl)
    );

    gt_pulse_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_lvl    (q_lvl),
        .sp_mode  (sp_mode),
        .arm_set  (arm_set),
        .gate_use (gate_use),
        .ctl_on   (ctl_on),
        .irq_clr  (irq_clr),
        .win      (win),
        .armed    (armed),
        .gate_irq (gate_irq)
    );

    assign inc      = ctl_on & cnt_en & (~gate_use | win);
    assign gate_val = win;

    gt_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );
endmodule

// File: rtl/gt_checker.sv
module gt_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_on,
    input logic             gate_use,
    input logic             sp_mode,
    input logic             irq_clr,
    input logic             ovf_clr,
    input logic             armed,
    input logic [WIDTH-1:0] count,
    input logic             gate_irq,
    input logic             ovf_flag
);
    localparam logic [WIDTH-1:0] TOP = '1;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_on |=> $stable(count)); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_irq && !irq_clr) |=> gate_irq); // R5
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_use && sp_mode && !armed) |=> $stable(count)); // R7
    AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_mode |=> !armed); // R9
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == TOP && count == '0) |-> ovf_flag); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R11
endmodule

bind gated_pulse_timer gt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_on   (ctl_on),
    .gate_use (gate_use),
    .sp_mode  (sp_mode),
    .irq_clr  (irq_clr),
    .ovf_clr  (ovf_clr),
    .armed    (armed),
    .count    (count),
    .gate_irq (gate_irq),
    .ovf_flag (ovf_flag)
);

// File: tb/test_gated_pulse_timer.sv
module test_gated_pulse_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, gate_in = 1'b0, ctl_on = 1'b0, gate_use = 1'b0;
    logic        gate_inv = 1'b0, tgl_mode = 1'b0, sp_mode = 1'b0;
    logic        arm_set = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
    logic        gate_val, armed, gate_irq, ovf_flag;
    logic [15:0] count;
    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] base;

    always #10 clk = ~clk;

    gated_pulse_timer i_gated_pulse_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate_in(gate_in),
        .ctl_on(ctl_on), .gate_use(gate_use), .gate_inv(gate_inv),
        .tgl_mode(tgl_mode), .sp_mode(sp_mode), .arm_set(arm_set),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .gate_val(gate_val),
        .armed(armed), .count(count), .gate_irq(gate_irq), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_gate(input logic lvl, input int n);
        gate_in = lvl;
        cyc(n);
        gate_in = ~lvl;
    endtask

    task automatic do_arm();
        arm_set = 1'b1;
        cyc(1);
        arm_set = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        cyc(1);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(count == 0, "R1 count", count, 0);
        chk(armed == 0 && gate_irq == 0 && ovf_flag == 0, "R1 flags",
            {armed, gate_irq, ovf_flag}, 0);
    endtask

    task automatic t_free();
        ctl_on = 1'b1; gate_use = 1'b0;
        base = count;
        for (int i = 0; i < 20; i++) begin
            cnt_en = i[0];
            cyc(1);
        end
        cnt_en = 1'b0;
        cyc(1);
        chk(count - base == 10, "R2 free count", count - base, 10);
    endtask

    task automatic t_off();
        ctl_on = 1'b0; cnt_en = 1'b1;
        base = count;
        pulse_gate(1'b1, 4);
        cyc(6);
        chk(count == base, "R3 disabled hold", count, base);
        cnt_en = 1'b0;
    endtask

    task automatic t_gated();
        gate_use = 1'b1; ctl_on = 1'b1; cnt_en = 1'b1;
        base = count;
        pulse_gate(1'b1, 7);
        cyc(6);
        chk(count - base == 7, "R4 gated high", count - base, 7);
        chk(gate_irq == 1, "R5 irq set at window end", gate_irq, 1);
        clear_irq();
        cyc(1);
        chk(gate_irq == 0, "R5 irq cleared", gate_irq, 0);
        ctl_on = 1'b0; gate_inv = 1'b1; gate_in = 1'b1;
        cyc(4);
        ctl_on = 1'b1;
        clear_irq();
        base = count;
        gate_in = 1'b0;
        cyc(3);
        chk(gate_val == 1, "R4 gate_val inverted", gate_val, 1);
        cyc(2);
        gate_in = 1'b1;
        cyc(6);
        chk(count - base == 5, "R4 inverted polarity", count - base, 5);
        gate_inv = 1'b0; gate_in = 1'b0;
        cyc(4);
        clear_irq();
    endtask

    task automatic t_single();
        sp_mode = 1'b1;
        cyc(2);
        do_arm();
        chk(armed == 1, "R6 armed after arm", armed, 1);
        base = count;
        pulse_gate(1'b1, 6);
        cyc(4);
        chk(count - base == 6, "R6 one pulse counted", count - base, 6);
        chk(armed == 0, "R6 self clear", armed, 0);
        clear_irq();
        base = count;
        pulse_gate(1'b1, 5);
        cyc(6);
        chk(count == base, "R7 later pulse ignored", count, base);
        chk(gate_irq == 0, "R7 no irq while done", gate_irq, 0);
        do_arm();
        base = count;
        pulse_gate(1'b1, 3);
        cyc(5);
        chk(count - base == 3, "R7 re-arm counts", count - base, 3);
        gate_in = 1'b1;
        cyc(4);
        do_arm();
        base = count;
        cyc(4);
        gate_in = 1'b0;
        cyc(3);
        chk(count == base, "R8 no count on held level", count, base);
        pulse_gate(1'b1, 4);
        cyc(5);
        chk(count - base == 4, "R8 waits for next rise", count - base, 4);
        do_arm();
        sp_mode = 1'b0;
        cyc(1);
        chk(armed == 0, "R9 mode clear cancels", armed, 0);
    endtask

    task automatic t_toggle();
        tgl_mode = 1'b1; sp_mode = 1'b1;
        cyc(3);
        do_arm();
        base = count;
        for (int k = 0; k < 3; k++) begin
            pulse_gate(1'b1, 3);
            cyc(5);
        end
        cyc(6);
        chk(count - base == 8, "R10 one full period", count - base, 8);
        chk(armed == 0, "R10 done after period", armed, 0);
        tgl_mode = 1'b0; sp_mode = 1'b0;
        cyc(2);
    endtask

    task automatic t_wrap();
        int n;
        gate_use = 1'b0; ctl_on = 1'b1;
        n = 65535 - int'(count);
        cnt_en = 1'b1;
        cyc(n);
        cnt_en = 1'b0;
        cyc(1);
        chk(count == 16'hFFFF && ovf_flag == 0, "R11 at top", count, 16'hFFFF);
        cnt_en = 1'b1;
        cyc(1);
        cnt_en = 1'b0;
        cyc(1);
        chk(count == 0, "R11 wrap to zero", count, 0);
        chk(ovf_flag == 1, "R11 ovf set", ovf_flag, 1);
        ovf_clr = 1'b1;
        cyc(1);
        ovf_clr = 1'b0;
        cyc(1);
        chk(ovf_flag == 0, "R11 ovf cleared", ovf_flag, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_free();
        t_off();
        t_gated();
        t_single();
        t_toggle();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule